// File: doc/BRIEF.md
# Run-of-Four Equal-Bit Detector

This block watches a one-bit serial input that it samples on every rising clock edge. Its single output goes high once the last four samples all hold the same value. Runs of ones and runs of zeros are both detected, and runs may overlap. A long run therefore keeps the output high on every edge from the fourth equal sample onwards.

The block is a nine-state Moore machine with one idle state and two chains of four states, one chain for each polarity. The state register is visible on an output port so the current state can be observed. A parameter chooses how the states are stored:
- a one-hot code in which the idle state is all zeros, held in 9 bits;
- a plain 4-bit binary count.

Reset is synchronous and active-low. The input is a plain level that is taken on every edge. It has no valid/ready handshake and no back-pressure, so a caller that holds a value for N edges supplies N samples.

Top module: `run4_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is the idle state. The idle state is all zeros in both encodings, and `z_o` is 0 there.
- R2: After the fourth consecutive rising edge that samples `w_i`=1, `z_o` is 1.
- R3: After the fourth consecutive rising edge that samples `w_i`=0, `z_o` is 1.
- R4: Runs overlap. Every further equal sample after the fourth keeps `z_o` at 1, and fewer than four equal samples leave it at 0.
- R5: A sample opposite to the current run moves the machine to the first state of the other polarity's chain, never to idle. `z_o` is 0 after that edge.
- R6: With `ENC_SEL`=0, `state_o` is 9 bits. Idle is 0. A zero-run of length k (k = 1 to 3, or 4 meaning four or more) sets bit 0 and bit k. A one-run of length k sets bit 0 and bit 4+k.
- R7: With `ENC_SEL`=1, `state_o` is 4 bits. Idle is 0, a zero-run of length k reads k, and a one-run of length k reads 4+k, for k = 1 to 4 (4 meaning four or more).
- R8: Reset in the middle of a run discards the count. After reset, three equal samples leave `z_o` at 0, and the fourth raises it.
- R9: `z_o` is 1 exactly when the state is the fourth state of either chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| w_i | input | 1 | Serial bit, sampled every edge |
| z_o | output | 1 | High after four or more equal samples |
| state_o | output | 9 (`ENC_SEL`=0) or 4 (`ENC_SEL`=1) | Current state code |

## Verification
Because `state_o` shows the state register directly, a wrong state code is visible on the first edge after it is taken. The one-hot form also shows an illegal code as a broken pattern: bit 0 missing, or other than one extra bit set. A counting fault that keeps the code legal, such as a skipped or repeated chain step, shows on `z_o` one edge early or one edge late against a reference run-length counter. A polarity mix-up shows the first time the input flips while a run is in progress.

// File: rtl/run4_pkg.sv
package run4_pkg;

  // Logical states: idle, four zero-run steps, four one-run steps.
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_Z1   = 4'd1,
    ST_Z2   = 4'd2,
    ST_Z3   = 4'd3,
    ST_Z4   = 4'd4,
    ST_O1   = 4'd5,
    ST_O2   = 4'd6,
    ST_O3   = 4'd7,
    ST_O4   = 4'd8
  } run_st_e;

  localparam int ENC_ONEHOT0 = 0;
  localparam int ENC_BINARY  = 1;
  localparam int NUM_STATES  = 9;

  function automatic int code_width(input int enc);
    return (enc == ENC_BINARY) ? 4 : NUM_STATES;
  endfunction

endpackage

// File: rtl/run4_codec.sv
module run4_codec
  import run4_pkg::*;
#(
  parameter int ENC_SEL = ENC_ONEHOT0,
  parameter int CW      = code_width(ENC_SEL)
) (
  input  run_st_e         st_i,
  output logic [CW-1:0]   code_o,
  input  logic [CW-1:0]   code_i,
  output run_st_e         st_o
);

  generate
    if (ENC_SEL == ENC_BINARY) begin : g_bin
      always_comb begin
        code_o = CW'(st_i);
      end
      always_comb begin
        if (code_i > CW'(NUM_STATES - 1)) st_o = ST_IDLE;
        else                              st_o = run_st_e'(code_i[3:0]);
      end
    end else begin : g_oh
      always_comb begin
        code_o = '0;
        if (st_i != ST_IDLE) begin
          code_o[0]            = 1'b1;
          code_o[int'(st_i)]   = 1'b1;
        end
      end
      always_comb begin
        st_o = ST_IDLE;
        if (code_i[0]) begin
          for (int k = 1; k < NUM_STATES; k++) begin
            if (code_i[k]) st_o = run_st_e'(k[3:0]);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/run4_step.sv
module run4_step
  import run4_pkg::*;
(
  input  run_st_e st_i,
  input  logic    w_i,
  output run_st_e nxt_o,
  output logic    z_o
);

  always_comb begin
    unique case (st_i)
      ST_IDLE: nxt_o = w_i ? ST_O1 : ST_Z1;
      ST_Z1:   nxt_o = w_i ? ST_O1 : ST_Z2;
      ST_Z2:   nxt_o = w_i ? ST_O1 : ST_Z3;
      ST_Z3:   nxt_o = w_i ? ST_O1 : ST_Z4;
      ST_Z4:   nxt_o = w_i ? ST_O1 : ST_Z4;
      ST_O1:   nxt_o = w_i ? ST_O2 : ST_Z1;
      ST_O2:   nxt_o = w_i ? ST_O3 : ST_Z1;
      ST_O3:   nxt_o = w_i ? ST_O4 : ST_Z1;
      ST_O4:   nxt_o = w_i ? ST_O4 : ST_Z1;
      default: nxt_o = ST_IDLE;
    endcase
  end

  // Moore output: the terminal state of either chain.
  assign z_o = (st_i == ST_Z4) || (st_i == ST_O4);

endmodule

// File: rtl/run4_detector.sv
module run4_detector
  import run4_pkg::*;
#(
  parameter int ENC_SEL = ENC_ONEHOT0,
  localparam int CW     = code_width(ENC_SEL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_i,
  output logic          z_o,
  output logic [CW-1:0] state_o
);

  logic [CW-1:0] state_q;
  logic [CW-1:0] state_d;
  run_st_e       cur_st;
  run_st_e       nxt_st;

  run4_codec #(.ENC_SEL(ENC_SEL), .CW(CW)) u_codec (
    .st_i   (nxt_st),
    .code_o (state_d),
    .code_i (state_q),
    .st_o   (cur_st)
  );

  run4_step u_step (
    .st_i  (cur_st),
    .w_i   (w_i),
    .nxt_o (nxt_st),
    .z_o   (z_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // Previous sample, kept only for the properties below.
  logic w_d;
  logic have_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_d <= 1'b0;
      w_d    <= 1'b0;
    end else begin
      have_d <= 1'b1;
      w_d    <= w_i;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (state_q == '0) && !z_o);

  assert_flip_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_d && (w_i != w_d)) |=> !z_o);

  assert_run_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (z_o && have_d && (w_i == w_d)) |=> z_o);

  assert_rise_after_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_o) |-> ($past(w_i) == $past(w_i, 2)));

  generate
    if (ENC_SEL == ENC_BINARY) begin : g_chk_bin
      assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= CW'(NUM_STATES - 1));
    end else begin : g_chk_oh
      assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0) || (state_q[0] && ($countones(state_q) == 2)));
    end
  endgenerate

endmodule

// File: tb/run4_detector_tb.sv
`timescale 1ns/1ps
module run4_detector_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       w = 1'b0;
  logic       z_oh, z_bin;
  logic [8:0] st_oh;
  logic [3:0] st_bin;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  run4_detector #(.ENC_SEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .w_i(w), .z_o(z_oh), .state_o(st_oh)
  );

  run4_detector #(.ENC_SEL(1)) u_dut_bin (
    .clk(clk), .rst_n(rst_n), .w_i(w), .z_o(z_bin), .state_o(st_bin)
  );

  typedef struct {
    logic       z;
    logic [3:0] idx;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference: run length (0 = idle) and run polarity.
  int   run_len = 0;
  logic run_pol = 1'b0;

  function automatic logic [8:0] oh_code(input logic [3:0] idx);
    logic [8:0] c;
    c = '0;
    if (idx != 0) begin
      c[0]   = 1'b1;
      c[idx] = 1'b1;
    end
    return c;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.z   = (run_len == 4);
    e.idx = (run_len == 0) ? 4'd0 : (run_pol ? 4'(4 + run_len) : 4'(run_len));
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input logic bit_in, input string tag);
    @(negedge clk);
    rst_n = 1'b1;
    w     = bit_in;
    if (run_len == 0 || bit_in != run_pol) begin
      run_pol = bit_in;
      run_len = 1;
    end else if (run_len < 4) begin
      run_len = run_len + 1;
    end
    push_exp(tag);
  endtask

  task automatic do_reset(input logic bit_in);
    @(negedge clk);
    rst_n   = 1'b0;
    w       = bit_in;
    run_len = 0;
    push_exp("R1");
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  // Monitor: pops one expectation per edge, compares both encodings.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(z_oh == e.z, e.tag, "z onehot", z_oh, e.z);
        check(z_bin == e.z, e.tag, "z binary", z_bin, e.z);
        check(st_oh == oh_code(e.idx), "R6", "state onehot", st_oh, oh_code(e.idx));
        check(st_bin == e.idx, "R7", "state binary", st_bin, e.idx);
        check(z_oh == (st_oh[4] | st_oh[8]), "R9", "z vs terminal", z_oh,
              st_oh[4] | st_oh[8]);
      end
    end
  end

  // Driver
  initial begin
    logic [7:0] lfsr;
    do_reset(1'b1);
    do_reset(1'b0);
    // R2 then R4: long run of ones
    for (int i = 0; i < 3; i++) step(1'b1, "R2");
    step(1'b1, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, "R4");
    // R5: flip into zero chain
    step(1'b0, "R5");
    // R3: zeros reaching four, then R4 overlap
    for (int i = 0; i < 3; i++) step(1'b0, "R3");
    step(1'b0, "R4");
    step(1'b0, "R4");
    step(1'b1, "R5");
    // R5: alternating never raises z
    for (int i = 0; i < 8; i++) step(i[0], "R5");
    // R8: reset mid-run
    for (int i = 0; i < 3; i++) step(1'b1, "R8");
    do_reset(1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, "R8");
    step(1'b1, "R8");
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, "R8");
    // R4: pseudo-random mix with runs of varied length
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((i % 16 < 6) ? 1'b1 : lfsr[0], "R4");
    end
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule